// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer with Pairwise-Age Refill

This block is a small fully associative translation buffer for instruction fetches, sitting in front of a larger unified translation buffer. A fetch request carries a virtual address and an address-space identifier. The block searches its four local entries first. A single match returns the physical address at once. On a local miss it raises a request to the unified buffer and waits for the answer. A unified hit is copied into a local slot, and that slot's index is reported with the translated address.

The victim slot is picked from a 6-bit pairwise-age state. Each bit records which of two entries was used less recently. Every successful hit or refill marks the entry used as the newest. A unified miss is reported as an instruction-side miss code. A multiple match in either buffer is passed through as a multiple-hit code and leaves the age state unchanged. Protection checks and exception raising are outside this block.

Top module: `itlb_fetch_xlate`

## Requirements
- R1: After reset all four local entries are invalid, `lru_o` is 0, `req_ready_o` is 1, and `resp_valid_o` and `utlb_req_o` are 0.
- R2: A request is accepted on a clock edge with `req_valid_i` and `req_ready_o` high. If exactly one local entry matches, `resp_valid_o` is high for one cycle, starting after the second edge from acceptance. It carries code 0 (hit), the matching slot in `resp_idx_o` and the translated address. No unified request is made.
- R3: Entry size code 0, 1, 2 and 3 selects a 1 KiB, 4 KiB, 64 KiB or 1 MiB page. Matching compares the virtual address above the page offset. The physical address is the entry's page number shifted left by 10, with the page offset bits taken from the virtual address.
- R4: An entry matches only when its identifier equals `req_asid_i`. A mismatch is treated as a local miss.
- R5: On a local miss, `utlb_req_o` rises with `utlb_vaddr_o` and `utlb_asid_o` equal to the request. Both are held until a cycle with `utlb_rsp_valid_i` high.
- R6: A unified response with code 0 (hit) writes the returned entry into the victim slot. It then reports code 0, the victim index, and the address translated through the returned entry.
- R7: A unified response with code 1 (miss) reports code 1 (instruction miss). No entry is written and `lru_o` is unchanged.
- R8: Two or more local matches, or a unified response with code 2, report code 2 (multiple hit) and leave `lru_o` unchanged.
- R9: `lru_o[5:0]` stand for control bits 31:26. The victim is chosen in this order: slot 0 if bits 31,30,29 are all 1; else slot 1 if bits 31,28,27 are 0,1,1; else slot 2 if bits 30,28,26 are 0,0,1; else slot 3.
- R10: Using slot 0 clears bits 31:29. Using slot 1 clears bits 28,27 and sets bit 31. Using slot 2 clears bit 26 and sets bits 30,28. Using slot 3 sets bits 29,27,26. All other bits are preserved.
- R11: From reset, over any sequence of fetches, the victim is the slot least recently hit or refilled, and a slot just used is never the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch translation request |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_vaddr_i | input | 32 | Fetch virtual address |
| req_asid_i | input | 8 | Address-space identifier of the fetch |
| resp_valid_o | output | 1 | Result strobe, one cycle |
| resp_code_o | output | 2 | 0 hit, 1 instruction miss, 2 multiple hit |
| resp_idx_o | output | 2 | Local slot used on a hit |
| resp_paddr_o | output | 32 | Translated physical address |
| lru_o | output | 6 | Pairwise-age state (control bits 31:26) |
| utlb_req_o | output | 1 | Lookup request to the unified buffer |
| utlb_vaddr_o | output | 32 | Address sent to the unified buffer |
| utlb_asid_o | output | 8 | Identifier sent to the unified buffer |
| utlb_rsp_valid_i | input | 1 | Unified answer strobe |
| utlb_rsp_code_i | input | 2 | 0 hit, 1 miss, 2 multiple hit |
| utlb_rsp_vpn_i | input | 22 | Returned virtual page number (address bits 31:10) |
| utlb_rsp_sz_i | input | 2 | Returned size code |
| utlb_rsp_ppn_i | input | 19 | Returned physical page number |
| utlb_rsp_asid_i | input | 8 | Returned identifier |

## Verification
The assertions assume that the unified side answers only while `utlb_req_o` is high, gives one answer per request, and returns an entry that really covers the requested address. They also assume the age state is only ever reached from reset through the update rule. Otherwise the state need not describe a consistent order, and a slot just used could still be chosen as victim. The stimulus keeps to this: a bench model of the unified buffer answers each request once after a random delay of zero to two cycles. Its page set does not overlap, except for one deliberate pair that produces a local multiple hit. New requests are issued only after the previous result has been seen.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W    = VA_W - PAGE_LSB;
  localparam int PPN_W    = 19;
  localparam int ASID_W   = 8;
  localparam int N_ENT    = 4;
  localparam int IDX_W    = $clog2(N_ENT);
  localparam int LRU_W    = N_ENT * (N_ENT - 1) / 2;
  localparam int CODE_W   = 2;

  localparam logic [CODE_W-1:0] RES_HIT   = 2'd0;
  localparam logic [CODE_W-1:0] RES_IMISS = 2'd1;
  localparam logic [CODE_W-1:0] RES_MULTI = 2'd2;

  localparam logic [CODE_W-1:0] U_HIT   = 2'd0;
  localparam logic [CODE_W-1:0] U_MISS  = 2'd1;
  localparam logic [CODE_W-1:0] U_MULTI = 2'd2;

  typedef struct packed {
    logic              v;
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        sz;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
  } tlb_ent_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return '1;
      2'd1:    return {{(VPN_W-2){1'b1}}, 2'b0};
      2'd2:    return {{(VPN_W-6){1'b1}}, 6'b0};
      default: return {{(VPN_W-10){1'b1}}, 10'b0};
    endcase
  endfunction

  function automatic logic [VA_W-1:0] xlate(input logic [PPN_W-1:0] ppn,
                                            input logic [1:0] sz,
                                            input logic [VA_W-1:0] va);
    logic [VA_W-1:0] base, off;
    base = {{(VA_W-PPN_W-PAGE_LSB){1'b0}}, ppn, {PAGE_LSB{1'b0}}};
    off  = ~{vpn_cmp_mask(sz), {PAGE_LSB{1'b0}}};
    return (base & ~off) | (va & off);
  endfunction
endpackage

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_i,
  input  logic [IDX_W-1:0] use_idx_i,
  output logic [IDX_W-1:0] victim_o,
  output logic [LRU_W-1:0] lru_o
);
  // bit 5..0 = control bits 31..26
  localparam logic [LRU_W-1:0] AND_M [N_ENT] = '{6'b000111, 6'b111001, 6'b111110, 6'b111111};
  localparam logic [LRU_W-1:0] OR_M  [N_ENT] = '{6'b000000, 6'b100000, 6'b010100, 6'b001011};

  logic [LRU_W-1:0] lru_q;

  always_comb begin
    if (lru_q[5:3] == 3'b111)                                  victim_o = 2'd0;
    else if ({lru_q[5], lru_q[2], lru_q[1]} == 3'b011)         victim_o = 2'd1;
    else if ({lru_q[4], lru_q[2], lru_q[0]} == 3'b001)         victim_o = 2'd2;
    else                                                       victim_o = 2'd3;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lru_q <= '0;
    else if (use_i) lru_q <= (lru_q & AND_M[use_idx_i]) | OR_M[use_idx_i];
  end

  assign lru_o = lru_q;

  AST_FRESH_NOT_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_i |=> victim_o != $past(use_idx_i)); // R11
  AST_IDLE_AGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i |=> lru_o == $past(lru_o)); // R10
endmodule

// File: rtl/itlb_array.sv
module itlb_array
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_ent_t          wr_ent_i,
  output logic              hit_o,
  output logic              multi_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [PPN_W-1:0]  hit_ppn_o,
  output logic [1:0]        hit_sz_o
);
  tlb_ent_t         ent_q [N_ENT];
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      ent_q[g] <= wr_ent_i;
    end

    assign match[g] = ent_q[g].v && (ent_q[g].asid == lk_asid_i) &&
                      (((lk_vpn_i ^ ent_q[g].vpn) & vpn_cmp_mask(ent_q[g].sz)) == '0);

    AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(g)) |=>
        ent_q[g].v && ent_q[g].vpn == $past(wr_ent_i.vpn) && ent_q[g].ppn == $past(wr_ent_i.ppn)); // R6
  end

  always_comb begin
    hit_idx_o = '0;
    hit_ppn_o = '0;
    hit_sz_o  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match[i]) begin
        hit_idx_o = IDX_W'(i);
        hit_ppn_o = ent_q[i].ppn;
        hit_sz_o  = ent_q[i].sz;
      end
    end
  end

  assign hit_o   = |match;
  assign multi_o = (match & (match - 1'b1)) != '0;
endmodule

// File: rtl/itlb_fetch_xlate.sv
module itlb_fetch_xlate
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [ASID_W-1:0] req_asid_i,
  output logic              resp_valid_o,
  output logic [CODE_W-1:0] resp_code_o,
  output logic [IDX_W-1:0]  resp_idx_o,
  output logic [VA_W-1:0]   resp_paddr_o,
  output logic [LRU_W-1:0]  lru_o,
  output logic              utlb_req_o,
  output logic [VA_W-1:0]   utlb_vaddr_o,
  output logic [ASID_W-1:0] utlb_asid_o,
  input  logic              utlb_rsp_valid_i,
  input  logic [CODE_W-1:0] utlb_rsp_code_i,
  input  logic [VPN_W-1:0]  utlb_rsp_vpn_i,
  input  logic [1:0]        utlb_rsp_sz_i,
  input  logic [PPN_W-1:0]  utlb_rsp_ppn_i,
  input  logic [ASID_W-1:0] utlb_rsp_asid_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_UWAIT} st_e;

  st_e               st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;

  logic              arr_hit, arr_multi;
  logic [IDX_W-1:0]  arr_idx, victim;
  logic [PPN_W-1:0]  arr_ppn;
  logic [1:0]        arr_sz;
  logic              wr_en;
  tlb_ent_t          wr_ent;
  logic              lru_use;
  logic [IDX_W-1:0]  lru_idx;

  logic              rsp_set;
  logic [CODE_W-1:0] code_d, code_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [VA_W-1:0]   pa_d, pa_q;
  logic              rv_q;

  itlb_array i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_vpn_i  (va_q[VA_W-1:PAGE_LSB]),
    .lk_asid_i (asid_q),
    .wr_en_i   (wr_en),
    .wr_idx_i  (victim),
    .wr_ent_i  (wr_ent),
    .hit_o     (arr_hit),
    .multi_o   (arr_multi),
    .hit_idx_o (arr_idx),
    .hit_ppn_o (arr_ppn),
    .hit_sz_o  (arr_sz)
  );

  itlb_lru i_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .use_i     (lru_use),
    .use_idx_i (lru_idx),
    .victim_o  (victim),
    .lru_o     (lru_o)
  );

  assign wr_ent = '{v: 1'b1, vpn: utlb_rsp_vpn_i, sz: utlb_rsp_sz_i,
                    ppn: utlb_rsp_ppn_i, asid: utlb_rsp_asid_i};

  always_comb begin
    st_d    = st_q;
    wr_en   = 1'b0;
    lru_use = 1'b0;
    lru_idx = '0;
    rsp_set = 1'b0;
    code_d  = RES_HIT;
    idx_d   = '0;
    pa_d    = '0;
    case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOK;
      ST_LOOK: begin
        if (arr_multi) begin
          rsp_set = 1'b1;
          code_d  = RES_MULTI;
          st_d    = ST_IDLE;
        end else if (arr_hit) begin
          rsp_set = 1'b1;
          idx_d   = arr_idx;
          pa_d    = xlate(arr_ppn, arr_sz, va_q);
          lru_use = 1'b1;
          lru_idx = arr_idx;
          st_d    = ST_IDLE;
        end else begin
          st_d = ST_UWAIT;
        end
      end
      ST_UWAIT: if (utlb_rsp_valid_i) begin
        rsp_set = 1'b1;
        st_d    = ST_IDLE;
        if (utlb_rsp_code_i == U_HIT) begin
          wr_en   = 1'b1;
          lru_use = 1'b1;
          lru_idx = victim;
          idx_d   = victim;
          pa_d    = xlate(utlb_rsp_ppn_i, utlb_rsp_sz_i, va_q);
        end else if (utlb_rsp_code_i == U_MULTI) begin
          code_d = RES_MULTI;
        end else begin
          code_d = RES_IMISS;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      asid_q <= '0;
      rv_q   <= 1'b0;
      code_q <= RES_HIT;
      idx_q  <= '0;
      pa_q   <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rsp_set;
      if (st_q == ST_IDLE && req_valid_i) begin
        va_q   <= req_vaddr_i;
        asid_q <= req_asid_i;
      end
      if (rsp_set) begin
        code_q <= code_d;
        idx_q  <= idx_d;
        pa_q   <= pa_d;
      end
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign resp_valid_o = rv_q;
  assign resp_code_o  = code_q;
  assign resp_idx_o   = idx_q;
  assign resp_paddr_o = pa_q;
  assign utlb_req_o   = (st_q == ST_UWAIT);
  assign utlb_vaddr_o = va_q;
  assign utlb_asid_o  = asid_q;

  AST_UREQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (utlb_req_o && !utlb_rsp_valid_i) |=> utlb_req_o && $stable(utlb_vaddr_o) && $stable(utlb_asid_o)); // R5
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R2
  AST_NONHIT_AGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o != RES_HIT) |-> lru_o == $past(lru_o)); // R8
  AST_UREQ_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_rsp_valid_i |-> utlb_req_o); // R5
endmodule

// File: tb/test_itlb_fetch_xlate.sv
`timescale 1ns/1ps
module test_itlb_fetch_xlate;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [7:0]  req_asid_i = '0;
  logic        resp_valid_o;
  logic [1:0]  resp_code_o;
  logic [1:0]  resp_idx_o;
  logic [31:0] resp_paddr_o;
  logic [5:0]  lru_o;
  logic        utlb_req_o;
  logic [31:0] utlb_vaddr_o;
  logic [7:0]  utlb_asid_o;
  logic        utlb_rsp_valid_i = 1'b0;
  logic [1:0]  utlb_rsp_code_i = '0;
  logic [21:0] utlb_rsp_vpn_i = '0;
  logic [1:0]  utlb_rsp_sz_i = '0;
  logic [18:0] utlb_rsp_ppn_i = '0;
  logic [7:0]  utlb_rsp_asid_i = '0;

  always #4 clk = ~clk;

  itlb_fetch_xlate i_itlb_fetch_xlate (.*, .clk_i(clk));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // unified buffer contents: base va, size code, ppn, asid
  logic [31:0] u_va   [8];
  logic [1:0]  u_sz   [8];
  logic [18:0] u_ppn  [8];
  logic [7:0]  u_asid [8];

  function automatic logic [31:0] page_off(input logic [1:0] sz);
    int unsigned sh;
    sh = (sz == 2'd0) ? 10 : (sz == 2'd1) ? 12 : (sz == 2'd2) ? 16 : 20;
    return (32'd1 << sh) - 32'd1;
  endfunction

  task automatic u_lookup(input logic [31:0] va, input logic [7:0] asid, output logic [1:0] code,
                          output int k);
    code = 2'd1;
    k = 0;
    if (va[31:16] == 16'h7000) code = 2'd2;
    else
      for (int i = 7; i >= 0; i--)
        if (u_asid[i] == asid && (va & ~page_off(u_sz[i])) == (u_va[i] & ~page_off(u_sz[i]))) begin
          code = 2'd0;
          k = i;
        end
  endtask

  // reference model
  bit          m_v    [4];
  logic [31:0] m_va   [4];
  logic [1:0]  m_sz   [4];
  logic [18:0] m_ppn  [4];
  logic [7:0]  m_asid [4];
  int          age    [4];

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_v[i] = 1'b0;
      age[i] = i;
    end
  endtask

  task automatic touch(input int k);
    for (int j = 0; j < 4; j++) if (age[j] < age[k]) age[j]++;
    age[k] = 0;
  endtask

  function automatic logic [5:0] model_lru();
    return {age[0] > age[1], age[0] > age[2], age[0] > age[3],
            age[1] > age[2], age[1] > age[3], age[2] > age[3]};
  endfunction

  task automatic model_fetch(input logic [31:0] va, input logic [7:0] asid, output logic [1:0] code,
                             output int idx, output logic [31:0] pa, output logic [5:0] lru, output bit ureq);
    int nm, hk, uk, vic;
    logic [1:0] uc;
    nm = 0; hk = 0; ureq = 0; idx = 0; pa = '0;
    for (int i = 0; i < 4; i++)
      if (m_v[i] && m_asid[i] == asid && (va & ~page_off(m_sz[i])) == (m_va[i] & ~page_off(m_sz[i]))) begin
        nm++;
        hk = i;
      end
    if (nm > 1) code = 2'd2;
    else if (nm == 1) begin
      code = 2'd0; idx = hk;
      pa = ({m_ppn[hk], 10'b0} & ~page_off(m_sz[hk])) | (va & page_off(m_sz[hk]));
      touch(hk);
    end else begin
      ureq = 1;
      u_lookup(va, asid, uc, uk);
      code = uc;
      if (uc == 2'd0) begin
        vic = 0;
        for (int i = 1; i < 4; i++) if (age[i] > age[vic]) vic = i;
        m_v[vic] = 1'b1; m_va[vic] = u_va[uk]; m_sz[vic] = u_sz[uk];
        m_ppn[vic] = u_ppn[uk]; m_asid[vic] = u_asid[uk];
        idx = vic;
        pa = ({u_ppn[uk], 10'b0} & ~page_off(u_sz[uk])) | (va & page_off(u_sz[uk]));
        touch(vic);
      end
    end
    lru = model_lru();
  endtask

  // drive one fetch through the block and the unified-buffer stand-in
  task automatic fetch(input logic [31:0] va, input logic [7:0] asid, input int dly,
                       output logic [1:0] code, output logic [1:0] idx, output logic [31:0] pa,
                       output logic [5:0] lru, output bit ureq);
    int w;
    bit done;
    logic [1:0] uc;
    int uk;
    ureq = 0; w = 0; done = 0;
    code = '0; idx = '0; pa = '0; lru = '0;
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va; req_asid_i = asid;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int t = 0; t < 40 && !done; t++) begin
      @(negedge clk);
      utlb_rsp_valid_i = 1'b0;
      if (resp_valid_o) begin
        code = resp_code_o; idx = resp_idx_o; pa = resp_paddr_o; lru = lru_o;
        done = 1;
      end else if (utlb_req_o) begin
        if (!ureq) begin
          chk(utlb_vaddr_o == va && utlb_asid_o == asid, "R5 unified request fields", utlb_vaddr_o, va);
          ureq = 1;
        end
        if (w >= dly) begin
          u_lookup(va, asid, uc, uk);
          utlb_rsp_valid_i = 1'b1; utlb_rsp_code_i = uc;
          utlb_rsp_vpn_i = u_va[uk][31:10]; utlb_rsp_sz_i = u_sz[uk];
          utlb_rsp_ppn_i = u_ppn[uk]; utlb_rsp_asid_i = u_asid[uk];
        end
        w++;
      end else if (ureq) begin
        chk(1'b0, "R5 request dropped before answer", 32'd0, 32'd1);
      end
    end
    if (!done) chk(1'b0, "R2 no result", 32'd0, 32'd1);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic [1:0]  code;
    logic [1:0]  idx;
    logic [31:0] pa;
    logic [5:0]  lru;
    logic        ureq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h1000_0123, 8'd1, 2'd0, 2'd3, 32'h0004_0123, 6'h0B, 1'b1},
    '{32'h1000_0FFC, 8'd1, 2'd0, 2'd3, 32'h0004_0FFC, 6'h0B, 1'b0},
    '{32'h2000_ABCD, 8'd1, 2'd0, 2'd2, 32'h0008_ABCD, 6'h1E, 1'b1},
    '{32'h3001_2345, 8'd1, 2'd0, 2'd1, 32'h0101_2345, 6'h38, 1'b1},
    '{32'h4000_07FF, 8'd1, 2'd0, 2'd0, 32'h000C_CFFF, 6'h00, 1'b1},
    '{32'h1000_0004, 8'd2, 2'd1, 2'd0, 32'h0000_0000, 6'h00, 1'b1},
    '{32'h5000_0010, 8'd2, 2'd0, 2'd3, 32'h0014_0010, 6'h0B, 1'b1},
    '{32'h1000_0008, 8'd1, 2'd0, 2'd2, 32'h0004_0008, 6'h1E, 1'b1},
    '{32'h7000_0000, 8'd1, 2'd2, 2'd0, 32'h0000_0000, 6'h1E, 1'b1},
    '{32'h2000_0000, 8'd1, 2'd0, 2'd1, 32'h0008_0000, 6'h38, 1'b1},
    '{32'h8000_0400, 8'd1, 2'd0, 2'd0, 32'h0026_6400, 6'h00, 1'b1},
    '{32'h8000_0000, 8'd1, 2'd0, 2'd3, 32'h0200_0000, 6'h0B, 1'b1},
    '{32'h8000_0400, 8'd1, 2'd2, 2'd0, 32'h0000_0000, 6'h0B, 1'b0},
    '{32'h1000_0010, 8'd1, 2'd0, 2'd2, 32'h0004_0010, 6'h1E, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0]  c, ec;
    logic [1:0]  ix;
    logic [31:0] p, ep;
    logic [5:0]  l, el;
    bit          ur, eur;
    int          eix;
    string       tag;

    u_va[0] = 32'h1000_0000; u_sz[0] = 2'd1; u_ppn[0] = 19'h00100; u_asid[0] = 8'd1;
    u_va[1] = 32'h2000_0000; u_sz[1] = 2'd2; u_ppn[1] = 19'h00200; u_asid[1] = 8'd1;
    u_va[2] = 32'h3000_0000; u_sz[2] = 2'd3; u_ppn[2] = 19'h04000; u_asid[2] = 8'd1;
    u_va[3] = 32'h4000_0400; u_sz[3] = 2'd0; u_ppn[3] = 19'h00333; u_asid[3] = 8'd1;
    u_va[4] = 32'h5000_0000; u_sz[4] = 2'd1; u_ppn[4] = 19'h00500; u_asid[4] = 8'd2;
    u_va[5] = 32'h6000_0000; u_sz[5] = 2'd1; u_ppn[5] = 19'h00600; u_asid[5] = 8'd1;
    u_va[6] = 32'h8000_0400; u_sz[6] = 2'd0; u_ppn[6] = 19'h00999; u_asid[6] = 8'd1;
    u_va[7] = 32'h8000_0000; u_sz[7] = 2'd3; u_ppn[7] = 19'h08000; u_asid[7] = 8'd1;
    model_reset();

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(resp_valid_o == 1'b0 && utlb_req_o == 1'b0, "R1 strobes low", {30'd0, resp_valid_o, utlb_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(lru_o == 6'h00, "R1 age state", {26'd0, lru_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      fetch(VEC[v].va, VEC[v].asid, v % 3, c, ix, p, l, ur);
      model_fetch(VEC[v].va, VEC[v].asid, ec, eix, ep, el, eur);
      tag = (VEC[v].code == 2'd1) ? "R7" : (VEC[v].code == 2'd2) ? "R8" : VEC[v].ureq ? "R6" : "R2";
      chk(c == VEC[v].code, {tag, " code"}, {30'd0, c}, {30'd0, VEC[v].code});
      chk(ur == VEC[v].ureq, "R5 unified request made", {31'd0, ur}, {31'd0, VEC[v].ureq});
      if (VEC[v].code == 2'd0) begin
        chk(ix == VEC[v].idx, VEC[v].ureq ? "R9 victim slot" : "R2 hit slot", {30'd0, ix}, {30'd0, VEC[v].idx});
        chk(p == VEC[v].pa, "R3 physical address", p, VEC[v].pa);
      end
      chk(l == VEC[v].lru, "R10 age bits", {26'd0, l}, {26'd0, VEC[v].lru});
    end

    // R4: page held locally under another identifier must not hit
    fetch(32'h2000_0040, 8'd3, 1, c, ix, p, l, ur);
    model_fetch(32'h2000_0040, 8'd3, ec, eix, ep, el, eur);
    chk(ur == 1'b1, "R4 identifier mismatch goes to unified", {31'd0, ur}, 32'd1);
    chk(c == 2'd1, "R4 R7 instruction miss code", {30'd0, c}, 32'd1);
    chk(l == 6'h1E, "R7 age bits kept", {26'd0, l}, 32'h1E);

    // random sequences against the pairwise-age model
    for (int n = 0; n < 300; n++) begin
      int k;
      logic [31:0] va;
      logic [7:0]  as;
      k = $urandom % 8;
      as = 8'd1;
      if (k < 6) begin
        va = u_va[k] + ($urandom & page_off(u_sz[k]));
        as = (($urandom % 8) == 0) ? 8'd3 : u_asid[k];
      end else if (k == 6) va = 32'h9000_0000 + ($urandom % 4096);
      else                 va = 32'h7000_0000 + ($urandom % 4096);
      fetch(va, as, $urandom % 3, c, ix, p, l, ur);
      model_fetch(va, as, ec, eix, ep, el, eur);
      chk(c == ec, "R11 code", {30'd0, c}, {30'd0, ec});
      if (ec == 2'd0) begin
        chk(ix == 2'(eix), "R11 slot", {30'd0, ix}, eix);
        chk(p == ep, "R3 address", p, ep);
      end
      chk(l == el, "R11 age bits", {26'd0, l}, {26'd0, el});
      chk(ur == eur, "R5 unified request made", {31'd0, ur}, {31'd0, eur});
    end

    // R1: reset mid-run empties the buffer
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    chk(lru_o == 6'h00, "R1 age state after reset", {26'd0, lru_o}, 32'd0);
    fetch(32'h1000_0123, 8'd1, 0, c, ix, p, l, ur);
    chk(ur == 1'b1, "R1 entries invalid after reset", {31'd0, ur}, 32'd1);
    chk(ix == 2'd3 && c == 2'd0, "R9 first victim slot 3", {30'd0, ix}, 32'd3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule